// File: doc/BRIEF.md
# Paged Register Bank with Broadcast Writes

This block is the register file that sits behind a serial configuration port. The serial engine decodes each transaction and presents it here as a 15-bit address, a byte of write data, and separate write and read strobes. The address space has two windows. The lowest window holds 32 global registers. These are the same no matter which page is selected. The next window holds 32 byte-wide registers, and these are repeated across 64 pages.

A set of page-select bits in the global window picks the page. Each page has one bit, and the bits are packed eight to a register starting at global offset 0x10. Several bits may be set at once. A write to the paged window then lands in every selected page in the same cycle, which gives a broadcast. A read while several pages are selected returns the lowest-numbered selected page.

The global window also holds the control fields that the serial engine reads back:
- a port-width select (three-wire or four-wire);
- an address-direction flag;
- a streaming-addressing type;
- a self-clearing soft reset. The soft reset returns everything to its power-up value except the first two global registers.

Top module: `pgreg_bank`

## Requirements
- R1: After the synchronous reset, the select registers read 0x01 at offset 0x10 and 0x00 at offsets 0x11 to 0x17, so only page 0 is selected. Every other global register and every paged register reads 0x00, and rd_valid is low.
- R2: A read strobe in one cycle yields rdata and a one-cycle rd_valid pulse at the next rising edge. The value returned is the state before any write in that same cycle.
- R3: Addresses 0x00 to 0x1F reach one shared set of global registers, independent of the page selection.
- R4: Page k is selected by bit k%8 of the global register at offset 0x10 + k/8. A paged register written with only page k selected reads back with only page k selected, and no other page is changed.
- R5: A write to a paged offset (0x20 to 0x3F) while several select bits are set updates every selected page in the same cycle.
- R6: A read of a paged offset with several pages selected returns the value held by the lowest-numbered selected page.
- R7: With no select bit set, paged reads return 0x00 and paged writes change no page.
- R8: Addresses 0x40 and above read 0x00, and writes to them change no register.
- R9: Writing 1 to bit 0 of global offset 0x00 starts a soft reset. The soft reset takes effect at the next clock edge. It restores every register except global offsets 0x00 and 0x01, including the select registers (back to page 0 only). Bit 0 always reads 0.
- R10: cfg_four_wire follows bit 1 of global offset 0x00. cfg_ascend follows bit 0 of offset 0x02, and cfg_addr_type follows bit 1 of offset 0x02. Each output changes at the clock edge that stores the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 15 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| rd_valid | output | 1 | High for one cycle when rdata holds a fresh read |
| cfg_four_wire | output | 1 | Port-width select |
| cfg_ascend | output | 1 | Address-direction flag |
| cfg_addr_type | output | 1 | Streaming addressing-type flag |

## Verification
Each page is exercised on its own, and the bench confirms that the page's contents survive traffic to every other page. A select bit that lands on the wrong page, or a write enable that leaks, therefore shows up as a mismatched byte on the next read of the affected page. Faults in the broadcast path, the priority choice and the empty selection show up on rdata one cycle after the read strobe. An incomplete or over-reaching soft reset shows up on the first read after the clearing edge: a stale paged value, a lost select default, or a wiped keep register.

// File: rtl/pgreg_pkg.sv
package pgreg_pkg;
  // global offsets with fixed meaning
  localparam int REG_CTRL  = 0;   // soft reset, port width
  localparam int REG_MODE  = 2;   // address direction, addressing type
  localparam int SEL_BASE  = 16;  // first page-select register
  localparam int KEEP_REGS = 2;   // offsets below this survive soft reset

  localparam int CTRL_SRST_BIT = 0;
  localparam int CTRL_4W_BIT   = 1;
  localparam int MODE_ASC_BIT  = 0;
  localparam int MODE_TYPE_BIT = 1;

  typedef enum logic [1:0] {RGN_GLOBAL, RGN_PAGED, RGN_NONE} region_e;
endpackage

// File: rtl/pgreg_global.sv
module pgreg_global
  import pgreg_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int WIN_WORDS = 32,
  parameter int NUM_PAGES = 64,
  localparam int OFS_W    = $clog2(WIN_WORDS),
  localparam int SEL_REGS = NUM_PAGES / DATA_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we,
  input  logic [OFS_W-1:0]     waddr,
  input  logic [DATA_W-1:0]    wdata,
  input  logic [OFS_W-1:0]     raddr,
  output logic [DATA_W-1:0]    rd,
  output logic [NUM_PAGES-1:0] page_sel,
  output logic                 srst_pulse,
  output logic                 cfg_four_wire,
  output logic                 cfg_ascend,
  output logic                 cfg_addr_type
);
  logic [DATA_W-1:0] g [WIN_WORDS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < WIN_WORDS; k++) g[k] <= DATA_W'(k == SEL_BASE);
      srst_pulse <= 1'b0;
    end else begin
      srst_pulse <= we && (int'(waddr) == REG_CTRL) && wdata[CTRL_SRST_BIT];
      if (we) begin
        if (int'(waddr) == REG_CTRL) begin
          g[waddr] <= wdata & ~(DATA_W'(1) << CTRL_SRST_BIT);
        end else begin
          g[waddr] <= wdata;
        end
      end
      if (srst_pulse) begin
        for (int k = KEEP_REGS; k < WIN_WORDS; k++) g[k] <= DATA_W'(k == SEL_BASE);
      end
    end
  end

  for (genvar r = 0; r < SEL_REGS; r++) begin : g_sel
    assign page_sel[r*DATA_W +: DATA_W] = g[SEL_BASE + r];
  end

  assign rd            = g[raddr];
  assign cfg_four_wire = g[REG_CTRL][CTRL_4W_BIT];
  assign cfg_ascend    = g[REG_MODE][MODE_ASC_BIT];
  assign cfg_addr_type = g[REG_MODE][MODE_TYPE_BIT];
endmodule

// File: rtl/pgreg_page.sv
module pgreg_page #(
  parameter int DATA_W    = 8,
  parameter int WIN_WORDS = 32,
  localparam int OFS_W    = $clog2(WIN_WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              we,
  input  logic [OFS_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [OFS_W-1:0]  raddr,
  output logic [DATA_W-1:0] rd
);
  logic [DATA_W-1:0] mem [WIN_WORDS];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      for (int k = 0; k < WIN_WORDS; k++) mem[k] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rd = mem[raddr];
endmodule

// File: rtl/pgreg_bank.sv
module pgreg_bank
  import pgreg_pkg::*;
#(
  parameter int ADDR_W    = 15,
  parameter int DATA_W    = 8,
  parameter int NUM_PAGES = 64,
  parameter int WIN_WORDS = 32,
  localparam int OFS_W    = $clog2(WIN_WORDS),
  localparam int PG_W     = $clog2(NUM_PAGES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rd_valid,
  output logic              cfg_four_wire,
  output logic              cfg_ascend,
  output logic              cfg_addr_type
);
  region_e                rgn;
  logic [NUM_PAGES-1:0]   page_sel;
  logic                   srst_pulse;
  logic [DATA_W-1:0]      glb_rd;
  logic [DATA_W-1:0]      page_rd [NUM_PAGES];
  logic [PG_W-1:0]        lo_idx;
  logic                   any_sel;
  logic [DATA_W-1:0]      rd_value;

  always_comb begin
    if (addr[ADDR_W-1:OFS_W] == '0)                          rgn = RGN_GLOBAL;
    else if (addr[ADDR_W-1:OFS_W] == (ADDR_W-OFS_W)'(1))     rgn = RGN_PAGED;
    else                                                     rgn = RGN_NONE;
  end

  pgreg_global #(
    .DATA_W(DATA_W), .WIN_WORDS(WIN_WORDS), .NUM_PAGES(NUM_PAGES)
  ) i_global (
    .clk(clk), .rst(rst),
    .we(wr_en && rgn == RGN_GLOBAL),
    .waddr(addr[OFS_W-1:0]), .wdata(wdata), .raddr(addr[OFS_W-1:0]),
    .rd(glb_rd), .page_sel(page_sel), .srst_pulse(srst_pulse),
    .cfg_four_wire(cfg_four_wire), .cfg_ascend(cfg_ascend),
    .cfg_addr_type(cfg_addr_type)
  );

  for (genvar p = 0; p < NUM_PAGES; p++) begin : g_page
    pgreg_page #(.DATA_W(DATA_W), .WIN_WORDS(WIN_WORDS)) i_page (
      .clk(clk), .rst(rst), .clr(srst_pulse),
      .we(wr_en && rgn == RGN_PAGED && page_sel[p]),
      .waddr(addr[OFS_W-1:0]), .wdata(wdata), .raddr(addr[OFS_W-1:0]),
      .rd(page_rd[p])
    );
  end

  // lowest-numbered selected page wins a read
  always_comb begin
    lo_idx  = '0;
    any_sel = |page_sel;
    for (int i = NUM_PAGES - 1; i >= 0; i--) begin
      if (page_sel[i]) lo_idx = PG_W'(i);
    end
  end

  always_comb begin
    case (rgn)
      RGN_GLOBAL: rd_value = glb_rd;
      RGN_PAGED:  rd_value = any_sel ? page_rd[lo_idx] : '0;
      default:    rd_value = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata    <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rdata <= rd_value;
    end
  end
endmodule

// File: rtl/pgreg_bank_chk.sv
module pgreg_bank_chk #(
  parameter int ADDR_W    = 15,
  parameter int DATA_W    = 8,
  parameter int NUM_PAGES = 64,
  parameter int WIN_WORDS = 32,
  localparam int OFS_W    = $clog2(WIN_WORDS)
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 wr_en,
  input logic                 rd_en,
  input logic [ADDR_W-1:0]    addr,
  input logic [DATA_W-1:0]    rdata,
  input logic                 rd_valid,
  input logic [NUM_PAGES-1:0] page_sel,
  input logic                 srst_pulse,
  input logic                 cfg_four_wire,
  input logic                 cfg_ascend,
  input logic                 cfg_addr_type
);
  // R1: reset state
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (rdata == '0 && !rd_valid && page_sel == NUM_PAGES'(1)));

  // R2: one-cycle read valid
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);
  a_r2_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid);

  // R7: empty selection reads zero
  a_r7_empty_sel_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en && page_sel == '0 && addr[ADDR_W-1:OFS_W] == (ADDR_W-OFS_W)'(1)) |=> rdata == '0);

  // R8: unmapped addresses read zero
  a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr[ADDR_W-1:OFS_W] > (ADDR_W-OFS_W)'(1)) |=> rdata == '0);

  // R9: soft reset lasts one cycle
  a_r9_srst_selfclear: assert property (@(posedge clk) disable iff (rst)
    srst_pulse |=> !srst_pulse);

  // R10: control outputs move only on a write or a soft reset
  a_r10_cfg_stable: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !srst_pulse) |=>
      ($stable(cfg_four_wire) && $stable(cfg_ascend) && $stable(cfg_addr_type)));
endmodule

bind pgreg_bank pgreg_bank_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_PAGES(NUM_PAGES), .WIN_WORDS(WIN_WORDS)
) i_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .rdata(rdata), .rd_valid(rd_valid), .page_sel(page_sel),
  .srst_pulse(srst_pulse), .cfg_four_wire(cfg_four_wire),
  .cfg_ascend(cfg_ascend), .cfg_addr_type(cfg_addr_type)
);

// File: tb/test_pgreg_bank.sv
module test_pgreg_bank;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [14:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        rd_valid;
  logic        cfg_four_wire, cfg_ascend, cfg_addr_type;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pgreg_bank i_pgreg_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid),
    .cfg_four_wire(cfg_four_wire), .cfg_ascend(cfg_ascend),
    .cfg_addr_type(cfg_addr_type)
  );

  function automatic logic [7:0] pat(input int p, input int o);
    return 8'((p * 5 + o * 11 + 3) & 255);
  endfunction

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [14:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [14:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic sel_mask(input logic [63:0] m);
    for (int r = 0; r < 8; r++) wr(15'(16 + r), m[r*8 +: 8]);
  endtask

  logic [7:0] v;

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset contents
    for (int r = 0; r < 8; r++) begin
      rd(15'(16 + r), v);
      chk("R1 select default", v, (r == 0) ? 8'h01 : 8'h00);
    end
    rd(15'h00, v); chk("R1 global 0", v, 8'h00);
    rd(15'h3F, v); chk("R1 page0 reg", v, 8'h00);

    // R2: valid timing and read-before-write ordering
    @(negedge clk);
    rd_en = 1'b1; wr_en = 1'b1; addr = 15'h07; wdata = 8'h9C;
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0;
    n_run++; if (rd_valid !== 1'b1) begin n_fail++; $display("FAIL R2 valid: got %b expected 1", rd_valid); end
    chk("R2 old value", rdata, 8'h00);
    @(negedge clk);
    n_run++; if (rd_valid !== 1'b0) begin n_fail++; $display("FAIL R2 valid drop: got %b expected 0", rd_valid); end
    rd(15'h07, v); chk("R2 new value", v, 8'h9C);

    // R4: each page alone, full sweep
    for (int p = 0; p < 64; p++) begin
      sel_mask(64'd1 << p);
      for (int o = 0; o < 32; o++) wr(15'(32 + o), pat(p, o));
    end
    for (int p = 0; p < 64; p++) begin
      sel_mask(64'd1 << p);
      for (int o = 0; o < 32; o++) begin
        rd(15'(32 + o), v); chk("R4 page isolation", v, pat(p, o));
      end
    end

    // R3: globals shared across pages
    sel_mask(64'd1 << 9);
    wr(15'h05, 8'h3C);
    sel_mask(64'd1 << 50);
    rd(15'h05, v); chk("R3 shared global", v, 8'h3C);
    sel_mask(64'd0);
    rd(15'h05, v); chk("R3 shared global no sel", v, 8'h3C);

    // R7: empty selection
    rd(15'h30, v); chk("R7 empty read", v, 8'h00);
    wr(15'h30, 8'h77);

    // R5: broadcast write to pages 3, 17, 40
    sel_mask((64'd1 << 3) | (64'd1 << 17) | (64'd1 << 40));
    wr(15'h25, 8'hA5);
    for (int p = 0; p < 64; p++) begin
      sel_mask(64'd1 << p);
      rd(15'h25, v);
      chk("R5 broadcast", v, (p == 3 || p == 17 || p == 40) ? 8'hA5 : pat(p, 5));
      rd(15'h30, v); chk("R7 write ignored", v, pat(p, 16));
    end

    // R6: lowest selected page wins
    sel_mask((64'd1 << 60) | (64'd1 << 5));
    rd(15'h21, v); chk("R6 lowest page", v, pat(5, 1));
    sel_mask((64'd1 << 63) | (64'd1 << 8) | (64'd1 << 31));
    rd(15'h3E, v); chk("R6 lowest page b", v, pat(8, 30));

    // R8: unmapped addresses
    sel_mask(64'd1);
    wr(15'h40, 8'hEE); wr(15'h7FFF, 8'hEE); wr(15'h1025, 8'hEE); wr(15'h0060, 8'hEE);
    rd(15'h40, v);   chk("R8 read 0x40", v, 8'h00);
    rd(15'h7FFF, v); chk("R8 read top", v, 8'h00);
    rd(15'h00, v);   chk("R8 no alias global", v, 8'h00);
    rd(15'h20, v);   chk("R8 no alias page", v, pat(0, 0));
    rd(15'h25, v);   chk("R8 no alias page b", v, pat(0, 5));

    // R10: control outputs
    wr(15'h00, 8'h02);
    chk("R10 four_wire", {7'd0, cfg_four_wire}, 8'h01);
    wr(15'h02, 8'h01);
    chk("R10 ascend", {7'd0, cfg_ascend}, 8'h01);
    chk("R10 addr_type", {7'd0, cfg_addr_type}, 8'h00);
    wr(15'h02, 8'h02);
    chk("R10 ascend off", {7'd0, cfg_ascend}, 8'h00);
    chk("R10 addr_type on", {7'd0, cfg_addr_type}, 8'h01);
    wr(15'h02, 8'h03);

    // R9: soft reset
    wr(15'h01, 8'h5A);
    sel_mask((64'd1 << 2) | (64'd1 << 44));
    wr(15'h00, 8'h03);
    @(negedge clk);
    rd(15'h00, v); chk("R9 ctrl kept, bit0 reads 0", v, 8'h02);
    rd(15'h01, v); chk("R9 keep reg", v, 8'h5A);
    rd(15'h02, v); chk("R9 mode cleared", v, 8'h00);
    rd(15'h05, v); chk("R9 global cleared", v, 8'h00);
    rd(15'h07, v); chk("R9 global cleared b", v, 8'h00);
    for (int r = 0; r < 8; r++) begin
      rd(15'(16 + r), v); chk("R9 select default", v, (r == 0) ? 8'h01 : 8'h00);
    end
    chk("R9 four_wire kept", {7'd0, cfg_four_wire}, 8'h01);
    chk("R9 ascend cleared", {7'd0, cfg_ascend}, 8'h00);
    chk("R9 addr_type cleared", {7'd0, cfg_addr_type}, 8'h00);
    for (int p = 0; p < 64; p += 7) begin
      sel_mask(64'd1 << p);
      rd(15'h20, v); chk("R9 page cleared", v, 8'h00);
      rd(15'h25, v); chk("R9 page cleared b", v, 8'h00);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule